// File: doc/BRIEF.md
# Vertical-Crosswise Column Multiplier

This block multiplies two unsigned 8-bit operands into a 16-bit product by working column by column rather than by adding shifted rows. Every single-bit product of the two operands is formed at once. The products are then grouped by the weight they carry: a product of operand bit i and operand bit j lands in column i+j. Each column adds its group of bit products to the carry handed up from the column beneath it. The lowest bit of that sum is the product bit for the column, and every bit above it moves up as the carry into the next column. That carry can be several bits wide.

The product is available combinationally on its own port. A parameterised output stage can also capture it on the clock edge that follows an asserted input strobe, and it raises a one-cycle valid flag when it does. When the stage is configured off, it passes the product and the strobe straight through. The operand width is a parameter with a default of 8. The widths of the column sums and carries are derived from it.

Top module: `vcm_mult`

## Requirements
- R1: For every pair of unsigned operands, `prod_now` equals `op_a * op_b` as a 16-bit unsigned value, in the same cycle as the operands, with no clock edge needed.
- R2: Bit 0 of `prod_now` equals `op_a[0] & op_b[0]`.
- R3: With `op_a` = 8'b1111_0000 and `op_b` = 8'b1010_1010, `prod_now` is 16'b1001_1111_0110_0000.
- R4: With both operands 8'hFF, `prod_now` is 16'hFE01. This case drives the widest column sums and carries, and the top carry supplies bit 15.
- R5: When either operand is zero, `prod_now` is zero, whatever the other operand holds.
- R6: While `rst_n` is low, `prod_q` is 0 and `out_valid` is 0.
- R7: If `in_valid` is high at a rising clock edge, then after that edge `out_valid` is 1 and `prod_q` holds the product of the operands present at that edge.
- R8: If `in_valid` is low at a rising clock edge, then after that edge `out_valid` is 0 and `prod_q` keeps its earlier value, even if the operands change.
- R9: When `in_valid` stays high on consecutive edges, `out_valid` stays high, and `prod_q` follows the product of the operands present at each edge, one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe asking the output stage to capture the product |
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 8 | Unsigned multiplier |
| prod_now | output | 16 | Combinational product |
| prod_q | output | 16 | Registered product |
| out_valid | output | 1 | High for the cycle after each captured strobe |

## Verification
The combinational product and the registered capture can fall in the same cycle. While `prod_q` presents the result of the previous operand pair, new operands already drive `prod_now`. The bench provokes this by holding `in_valid` high and changing the operands on every clock across all 65,536 operand pairs. At each falling edge it judges `prod_q` against the arithmetic product of the pair from the edge before, and it judges `prod_now` against the product of the pair it has just applied.

// File: rtl/vcm_pkg.sv
package vcm_pkg;

  // Width that holds the largest column sum: at most w bit products plus a
  // carry that is itself bounded by w, so 2*w in total.
  function automatic int col_sum_width(input int w);
    return $clog2(2 * w + 1);
  endfunction

  // Number of columns that produce one product bit each.
  function automatic int col_count(input int w);
    return 2 * w - 1;
  endfunction

endpackage

// File: rtl/vcm_bitprod.sv
module vcm_bitprod #(
  parameter int W = 8
) (
  input  logic [W-1:0]             a,
  input  logic [W-1:0]             b,
  output logic [2*W-2:0][W-1:0]    col_bits
);

  localparam int NCOL = vcm_pkg::col_count(W);

  // Slot i of column k carries a[i]&b[k-i] whenever k-i is a valid index.
  for (genvar k = 0; k < NCOL; k++) begin : g_col
    for (genvar i = 0; i < W; i++) begin : g_term
      localparam int J = k - i;
      if (J >= 0 && J < W) begin : g_live
        assign col_bits[k][i] = a[i] & b[J];
      end else begin : g_dead
        assign col_bits[k][i] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/vcm_column.sv
module vcm_column #(
  parameter int W  = 8,
  parameter int SW = 5
) (
  input  logic [W-1:0]    terms,
  input  logic [SW-2:0]   carry_in,
  output logic            res_bit,
  output logic [SW-2:0]   carry_out
);

  logic [SW-1:0] col_sum;

  always_comb begin
    col_sum = {1'b0, carry_in};
    for (int i = 0; i < W; i++) begin
      col_sum = col_sum + SW'(terms[i]);
    end
  end

  assign res_bit   = col_sum[0];
  assign carry_out = col_sum[SW-1:1];

endmodule

// File: rtl/vcm_outreg.sv
module vcm_outreg #(
  parameter int PW  = 16,
  parameter bit REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [PW-1:0] d,
  output logic [PW-1:0] q,
  output logic          vld
);

  if (REG) begin : g_reg
    logic [PW-1:0] q_r, q_nx;
    logic          vld_r, vld_nx;

    always_comb begin
      vld_nx = in_valid;
      q_nx   = q_r;
      if (in_valid) begin
        q_nx = d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_r   <= '0;
        vld_r <= 1'b0;
      end else begin
        q_r   <= q_nx;
        vld_r <= vld_nx;
      end
    end

    assign q   = q_r;
    assign vld = vld_r;
  end else begin : g_pass
    assign q   = d;
    assign vld = in_valid;
  end

endmodule

// File: rtl/vcm_mult.sv
module vcm_mult #(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  output logic [2*WIDTH-1:0] prod_now,
  output logic [2*WIDTH-1:0] prod_q,
  output logic               out_valid
);

  localparam int NCOL = vcm_pkg::col_count(WIDTH);
  localparam int SW   = vcm_pkg::col_sum_width(WIDTH);
  localparam int CW   = SW - 1;

  logic [NCOL-1:0][WIDTH-1:0] col_bits;
  logic [NCOL:0][CW-1:0]      carry;
  logic [NCOL-1:0]            res_bits;

  vcm_bitprod #(.W(WIDTH)) u_bits (
    .a        (op_a),
    .b        (op_b),
    .col_bits (col_bits)
  );

  assign carry[0] = '0;

  for (genvar k = 0; k < NCOL; k++) begin : g_chain
    vcm_column #(.W(WIDTH), .SW(SW)) u_col (
      .terms     (col_bits[k]),
      .carry_in  (carry[k]),
      .res_bit   (res_bits[k]),
      .carry_out (carry[k+1])
    );
  end

  // The top carry is at most 1 because the product fits in 2*WIDTH bits.
  assign prod_now = {|carry[NCOL], res_bits};

  vcm_outreg #(.PW(2*WIDTH), .REG(REG_OUT)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .d        (prod_now),
    .q        (prod_q),
    .vld      (out_valid)
  );

endmodule

// File: rtl/vcm_check.sv
module vcm_check #(
  parameter int W   = 8,
  parameter bit REG = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   op_b,
  input logic [2*W-1:0] prod_now,
  input logic [2*W-1:0] prod_q,
  input logic           out_valid
);

  assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
    prod_now == ((2*W)'(op_a) * (2*W)'(op_b)));

  assert_low_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prod_now[0] == (op_a[0] & op_b[0]));

  assert_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_a == '0 || op_b == '0) |-> prod_now == '0);

  if (REG) begin : g_reg_chk
    assert_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

    assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> prod_q == $past(prod_now));

    assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && $stable(prod_q));
  end

endmodule

bind vcm_mult vcm_check #(.W(WIDTH), .REG(REG_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .prod_now  (prod_now),
  .prod_q    (prod_q),
  .out_valid (out_valid)
);

// File: tb/vcm_mult_test.sv
module vcm_mult_test;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  op_a, op_b;
  logic [15:0] prod_now, prod_q;
  logic        out_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  vcm_mult uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .prod_now  (prod_now),
    .prod_q    (prod_q),
    .out_valid (out_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    logic [15:0] prev_exp;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    op_a     = 8'h00;
    op_b     = 8'h00;
    #15;
    chk("R6 prod_q in reset", 32'(prod_q), 32'h0);
    chk("R6 out_valid in reset", 32'(out_valid), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: combinational, no edge between drive and sample
    op_a = 8'd13; op_b = 8'd11; #1;
    chk("R1 no-edge product", 32'(prod_now), 32'd143);

    // R3: the worked example
    op_a = 8'b1111_0000; op_b = 8'b1010_1010; #1;
    chk("R3 example", 32'(prod_now), 32'b1001_1111_0110_0000);

    // R4: widest column sums
    op_a = 8'hFF; op_b = 8'hFF; #1;
    chk("R4 all ones", 32'(prod_now), 32'hFE01);

    // R5: zero operand
    op_a = 8'h00; op_b = 8'hFF; #1;
    chk("R5 a zero", 32'(prod_now), 32'h0);
    op_a = 8'hA7; op_b = 8'h00; #1;
    chk("R5 b zero", 32'(prod_now), 32'h0);

    // R2: low bit
    op_a = 8'h01; op_b = 8'h03; #1;
    chk("R2 low bit set", 32'(prod_now[0]), 32'h1);
    op_a = 8'h02; op_b = 8'hFF; #1;
    chk("R2 low bit clear", 32'(prod_now[0]), 32'h0);

    // R7 / R8: single strobe, then idle with changing operands
    @(negedge clk);
    op_a = 8'd200; op_b = 8'd77; in_valid = 1'b1;
    @(negedge clk);
    chk("R7 out_valid after strobe", 32'(out_valid), 32'h1);
    chk("R7 captured product", 32'(prod_q), 32'd15400);
    held = prod_q;
    in_valid = 1'b0; op_a = 8'd9; op_b = 8'd9;
    @(negedge clk);
    chk("R8 out_valid drops", 32'(out_valid), 32'h0);
    chk("R8 prod_q holds", 32'(prod_q), 32'(held));
    op_a = 8'd250; op_b = 8'd3;
    @(negedge clk);
    chk("R8 prod_q holds again", 32'(prod_q), 32'(held));

    // R1 / R9: exhaustive sweep with back-to-back strobes
    in_valid = 1'b1;
    prev_exp = '0;
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        @(negedge clk);
        if (x != 0 || y != 0) begin
          chk("R9 back-to-back prod_q", 32'(prod_q), 32'(prev_exp));
          chk("R9 out_valid stays high", 32'(out_valid), 32'h1);
        end
        op_a = 8'(x); op_b = 8'(y);
        #1;
        prev_exp = 16'(x * y);
        chk("R1 sweep product", 32'(prod_now), 32'(prev_exp));
      end
    end
    @(negedge clk);
    chk("R9 last capture", 32'(prod_q), 32'(prev_exp));
    in_valid = 1'b0;
    @(negedge clk);
    chk("R8 idle after sweep", 32'(out_valid), 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule